// File: doc/BRIEF.md
# Byte-Accessed Preset Counter Channel

This block is one up/down counter channel reached over an 8-bit bus that has two ports, chosen by a select line: a data port and a control port. The count value is never read or written directly. Software loads a preset register one byte at a time through the data port, then issues a control command that copies the preset into the counter. To read the count, a control command freezes a copy of the counter in an output latch, and the data port then returns that copy byte by byte. A single byte pointer, shared by data reads and data writes, picks the byte and steps from the low byte to the high byte on each access.

Count pulses (up, down), a noise indication and an index pulse come from a separate input decoder. The control port also loads three configuration registers: count mode, input control and index control. Four count modes are available: free-running wrap, range limit, non-recycle and modulo-N. Sticky borrow and carry flags report underflow and overflow. Reading the control port returns a status byte.

Top module: `pcnt_channel`

## Requirements
- R1: After reset the counter, preset, output latch and byte pointer are zero. The status byte reads 0x00 and `quad_mult_o` is 0. The mode is free-running wrap, counting is disabled, the index function is disabled, and preset-on-index is selected.
- R2: Each data-port write stores the bus byte into the preset byte chosen by the pointer. Byte 0 is bits 7:0 and byte 2 is bits 23:16. The pointer then steps 0, 1, 2, 0. Control byte 0x01 returns the pointer to 0.
- R3: Control byte 0x08 copies the preset into the counter at the next clock edge. No other bus access changes the counter.
- R4: Control byte 0x11 copies the counter into the output latch and returns the pointer to 0. Each data-port read returns the latch byte chosen by the pointer, low byte first, and steps the pointer. The latch keeps its value while counting goes on.
- R5: The status byte is read at the control port. Bit 0 is borrow, bit 1 is carry, bit 4 is noise error and bit 5 is direction (1 = the last accepted count pulse was up). All other bits read 0.
- R6: Count pulses act only while the input-enable bit is set. The input-enable bit is bit 0 of the control byte 0x40|cfg. A cycle in which up and down are both high does not count.
- R7: In wrap mode (mode field 00), counting up from 0xFFFFFF gives 0 and sets carry. Counting down from 0 gives 0xFFFFFF and sets borrow.
- R8: In range-limit mode (mode field 01), counting up holds the count once it is at or above the preset, and sets carry. Counting down at 0 holds the count and sets borrow.
- R9: In non-recycle mode (mode field 10), a wrap sets carry or borrow and then freezes the counter. The counter stays frozen until a preset transfer, an index load or a new mode-register write.
- R10: In modulo-N mode (mode field 11), counting up at or above the preset gives 0 and sets carry. Counting down at 0 gives the preset and sets borrow.
- R11: Control byte 0x02 or 0x04 clears borrow and carry, but not noise error. Control byte 0x06 clears noise error. Flags are sticky otherwise.
- R12: Control byte 0x20|cfg loads the mode register. The mode field is cfg bits 2:1. The multiplier field is cfg bits 4:3 and drives `quad_mult_o`.
- R13: Control byte 0x60|cfg loads the index control register. Bit 0 enables the index function and bit 1 selects the active level (1 = high). When enabled, the cycle in which `index_i` moves to the active level loads the counter. If bit 1 of the input-control byte is 0, the counter takes the preset; if that bit is 1, the counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_ctrl_i | input | 1 | 1 selects the control port, 0 selects the data port |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_rd_i | input | 1 | Read strobe for one cycle (data port steps the pointer) |
| bus_wdata_i | input | 8 | Write data byte |
| bus_rdata_o | output | 8 | Read data: latch byte or status byte |
| cnt_up_i | input | 1 | Count-up pulse from the decoder |
| cnt_dn_i | input | 1 | Count-down pulse from the decoder |
| noise_i | input | 1 | Noise event from the decoder |
| index_i | input | 1 | Index signal level |
| quad_mult_o | output | 2 | Multiplier setting for the decoder |

## Verification
Every register in the block updates at the clock edge that samples a write, count pulse or index transition. Its effect shows on the read path in the following cycle. `bus_rdata_o` itself is combinational from the latch, the pointer and the flags. So a read strobe shows its byte in the same cycle, and the pointer step shows on the next access. The bench drives inputs just after the falling edge and samples a moment later, still before the next rising edge. A behavioural model steps on each rising edge and is compared with both outputs at every such sample. Explicit byte and status reads are checked against hand-computed values, so each check sees exactly the state that the preceding edges produced.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

  typedef enum logic [1:0] {
    CM_WRAP      = 2'b00,
    CM_RANGE     = 2'b01,
    CM_NORECYCLE = 2'b10,
    CM_MODULO    = 2'b11
  } cnt_mode_e;

  // control byte groups, bits 7:5
  localparam logic [2:0] GRP_CMD   = 3'b000;
  localparam logic [2:0] GRP_MODE  = 3'b001;
  localparam logic [2:0] GRP_IOCTL = 3'b010;
  localparam logic [2:0] GRP_INDEX = 3'b011;

  // operation field, bits 3:1 of a command-group byte
  localparam logic [2:0] OP_CLR_BC_A = 3'b001;
  localparam logic [2:0] OP_CLR_BC_B = 3'b010;
  localparam logic [2:0] OP_CLR_ERR  = 3'b011;
  localparam logic [2:0] OP_TRANSFER = 3'b100;

  typedef struct packed {
    logic ptr_rst;
    logic latch;
    logic transfer;
    logic clr_bc;
    logic clr_err;
  } cmd_t;

endpackage

// File: rtl/pcnt_ctrl_dec.sv
module pcnt_ctrl_dec
  import pcnt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ctrl_wr_i,
  input  logic [7:0] wdata_i,
  output cmd_t      cmd_o,
  output logic      mode_wr_o,
  output cnt_mode_e mode_o,
  output logic [1:0] mult_o,
  output logic      ab_en_o,
  output logic      pidx_n_o,
  output logic      idx_en_o,
  output logic      idx_pol_o
);

  cnt_mode_e  mode_q, mode_d;
  logic [1:0] mult_q, mult_d;
  logic       ab_q, ab_d;
  logic       pidx_n_q, pidx_n_d;
  logic       idx_en_q, idx_en_d;
  logic       idx_pol_q, idx_pol_d;
  logic [2:0] grp;
  logic [2:0] op;

  assign grp = wdata_i[7:5];
  assign op  = wdata_i[3:1];

  // one-cycle command pulses
  always_comb begin
    cmd_o     = '0;
    mode_wr_o = 1'b0;
    if (ctrl_wr_i) begin
      unique case (grp)
        GRP_CMD: begin
          cmd_o.ptr_rst  = wdata_i[0];
          cmd_o.latch    = wdata_i[4];
          cmd_o.transfer = (op == OP_TRANSFER);
          cmd_o.clr_bc   = (op == OP_CLR_BC_A) || (op == OP_CLR_BC_B);
          cmd_o.clr_err  = (op == OP_CLR_ERR);
        end
        GRP_MODE: mode_wr_o = 1'b1;
        default: ;
      endcase
    end
  end

  // configuration next state
  always_comb begin
    mode_d    = mode_q;
    mult_d    = mult_q;
    ab_d      = ab_q;
    pidx_n_d  = pidx_n_q;
    idx_en_d  = idx_en_q;
    idx_pol_d = idx_pol_q;
    if (ctrl_wr_i) begin
      unique case (grp)
        GRP_MODE: begin
          mode_d = cnt_mode_e'(wdata_i[2:1]);
          mult_d = wdata_i[4:3];
        end
        GRP_IOCTL: begin
          ab_d     = wdata_i[0];
          pidx_n_d = wdata_i[1];
        end
        GRP_INDEX: begin
          idx_en_d  = wdata_i[0];
          idx_pol_d = wdata_i[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= CM_WRAP;
      mult_q    <= 2'b00;
      ab_q      <= 1'b0;
      pidx_n_q  <= 1'b0;
      idx_en_q  <= 1'b0;
      idx_pol_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      mult_q    <= mult_d;
      ab_q      <= ab_d;
      pidx_n_q  <= pidx_n_d;
      idx_en_q  <= idx_en_d;
      idx_pol_q <= idx_pol_d;
    end
  end

  assign mode_o    = mode_q;
  assign mult_o    = mult_q;
  assign ab_en_o   = ab_q;
  assign pidx_n_o  = pidx_n_q;
  assign idx_en_o  = idx_en_q;
  assign idx_pol_o = idx_pol_q;

endmodule

// File: rtl/pcnt_byte_port.sv
module pcnt_byte_port #(
  parameter int CNT_W = 24,
  localparam int BYTES = CNT_W / 8,
  localparam int PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_wr_i,
  input  logic             data_rd_i,
  input  logic             sel_ctrl_i,
  input  logic [7:0]       wdata_i,
  input  logic             ptr_rst_i,
  input  logic             latch_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [7:0]       status_i,
  output logic [CNT_W-1:0] preset_o,
  output logic [CNT_W-1:0] latch_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [7:0]       rdata_o
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(BYTES - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] preset_q, preset_d;
  logic [CNT_W-1:0] latch_q, latch_d;
  logic [7:0]       lat_byte;
  logic             step;

  assign step = data_wr_i || data_rd_i;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_rst_i)  ptr_d = '0;
    else if (step)  ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_preset
    always_comb begin
      preset_d[b*8 +: 8] = preset_q[b*8 +: 8];
      if (data_wr_i && (ptr_q == PTR_W'(b))) preset_d[b*8 +: 8] = wdata_i;
    end
  end

  assign latch_d = latch_i ? count_i : latch_q;

  always_comb begin
    lat_byte = 8'h00;
    for (int b = 0; b < BYTES; b++) begin
      if (ptr_q == PTR_W'(b)) lat_byte = latch_q[b*8 +: 8];
    end
  end

  assign rdata_o = sel_ctrl_i ? status_i : lat_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      preset_q <= '0;
      latch_q  <= '0;
    end else begin
      ptr_q    <= ptr_d;
      preset_q <= preset_d;
      latch_q  <= latch_d;
    end
  end

  assign preset_o = preset_q;
  assign latch_o  = latch_q;
  assign ptr_o    = ptr_q;

endmodule

// File: rtl/pcnt_index.sv
module pcnt_index (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic index_i,
  input  logic idx_en_i,
  input  logic idx_pol_i,
  output logic evt_o
);

  logic act;
  logic act_q;

  assign act   = (index_i == idx_pol_i);
  assign evt_o = idx_en_i && act && !act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;
  end

endmodule

// File: rtl/pcnt_core.sv
module pcnt_core
  import pcnt_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             noise_i,
  input  logic             ab_en_i,
  input  cnt_mode_e        mode_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             load_pre_i,
  input  logic             load_zero_i,
  input  logic             unfreeze_i,
  input  logic             clr_bc_i,
  input  logic             clr_err_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             borrow_o,
  output logic             carry_o,
  output logic             noise_o,
  output logic             dir_o,
  output logic             frozen_o
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic borrow_q, borrow_d, carry_q, carry_d;
  logic noise_q, noise_d, dir_q, dir_d, frz_q, frz_d;
  logic pulse, step, set_b, set_c;

  assign pulse = ab_en_i && (up_i ^ dn_i);
  assign step  = pulse && !frz_q;

  always_comb begin
    cnt_d = cnt_q;
    set_b = 1'b0;
    set_c = 1'b0;
    frz_d = frz_q && !unfreeze_i;
    if (load_pre_i) begin
      cnt_d = preset_i;
      frz_d = 1'b0;
    end else if (load_zero_i) begin
      cnt_d = '0;
      frz_d = 1'b0;
    end else if (step) begin
      unique case (mode_i)
        CM_WRAP, CM_NORECYCLE: begin
          if (up_i) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == MAXV) begin
              set_c = 1'b1;
              if (mode_i == CM_NORECYCLE) frz_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
            if (cnt_q == '0) begin
              set_b = 1'b1;
              if (mode_i == CM_NORECYCLE) frz_d = 1'b1;
            end
          end
        end
        CM_RANGE: begin
          if (up_i) begin
            if (cnt_q >= preset_i) set_c = 1'b1;
            else                   cnt_d = cnt_q + 1'b1;
          end else begin
            if (cnt_q == '0) set_b = 1'b1;
            else             cnt_d = cnt_q - 1'b1;
          end
        end
        CM_MODULO: begin
          if (up_i) begin
            if (cnt_q >= preset_i) begin
              cnt_d = '0;
              set_c = 1'b1;
            end else cnt_d = cnt_q + 1'b1;
          end else begin
            if (cnt_q == '0) begin
              cnt_d = preset_i;
              set_b = 1'b1;
            end else cnt_d = cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    borrow_d = (borrow_q && !clr_bc_i) || set_b;
    carry_d  = (carry_q && !clr_bc_i) || set_c;
    noise_d  = (noise_q && !clr_err_i) || noise_i;
    dir_d    = pulse ? up_i : dir_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      borrow_q <= 1'b0;
      carry_q  <= 1'b0;
      noise_q  <= 1'b0;
      dir_q    <= 1'b0;
      frz_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      borrow_q <= borrow_d;
      carry_q  <= carry_d;
      noise_q  <= noise_d;
      dir_q    <= dir_d;
      frz_q    <= frz_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign borrow_o = borrow_q;
  assign carry_o  = carry_q;
  assign noise_o  = noise_q;
  assign dir_o    = dir_q;
  assign frozen_o = frz_q;

endmodule

// File: rtl/pcnt_channel.sv
module pcnt_channel
  import pcnt_pkg::*;
#(
  parameter int CNT_W = 24,
  localparam int BYTES = CNT_W / 8,
  localparam int PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_sel_ctrl_i,
  input  logic       bus_wr_i,
  input  logic       bus_rd_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic       cnt_up_i,
  input  logic       cnt_dn_i,
  input  logic       noise_i,
  input  logic       index_i,
  output logic [1:0] quad_mult_o
);

  logic             ctrl_wr, data_wr, data_rd;
  cmd_t             cmd;
  logic             mode_wr;
  cnt_mode_e        mode;
  logic             ab_en, pidx_n, idx_en, idx_pol, idx_evt;
  logic [CNT_W-1:0] cnt, preset, latch;
  logic [PTR_W-1:0] ptr;
  logic             borrow, carry, noise, dir, frozen;
  logic [7:0]       status;

  assign ctrl_wr = bus_wr_i && bus_sel_ctrl_i;
  assign data_wr = bus_wr_i && !bus_sel_ctrl_i;
  assign data_rd = bus_rd_i && !bus_sel_ctrl_i;
  assign status  = {2'b00, dir, noise, 2'b00, carry, borrow};

  pcnt_ctrl_dec u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (ctrl_wr),
    .wdata_i   (bus_wdata_i),
    .cmd_o     (cmd),
    .mode_wr_o (mode_wr),
    .mode_o    (mode),
    .mult_o    (quad_mult_o),
    .ab_en_o   (ab_en),
    .pidx_n_o  (pidx_n),
    .idx_en_o  (idx_en),
    .idx_pol_o (idx_pol)
  );

  pcnt_byte_port #(.CNT_W(CNT_W)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_wr_i  (data_wr),
    .data_rd_i  (data_rd),
    .sel_ctrl_i (bus_sel_ctrl_i),
    .wdata_i    (bus_wdata_i),
    .ptr_rst_i  (cmd.ptr_rst),
    .latch_i    (cmd.latch),
    .count_i    (cnt),
    .status_i   (status),
    .preset_o   (preset),
    .latch_o    (latch),
    .ptr_o      (ptr),
    .rdata_o    (bus_rdata_o)
  );

  pcnt_index u_idx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .index_i   (index_i),
    .idx_en_i  (idx_en),
    .idx_pol_i (idx_pol),
    .evt_o     (idx_evt)
  );

  pcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .up_i        (cnt_up_i),
    .dn_i        (cnt_dn_i),
    .noise_i     (noise_i),
    .ab_en_i     (ab_en),
    .mode_i      (mode),
    .preset_i    (preset),
    .load_pre_i  (cmd.transfer || (idx_evt && !pidx_n)),
    .load_zero_i (idx_evt && pidx_n),
    .unfreeze_i  (mode_wr),
    .clr_bc_i    (cmd.clr_bc),
    .clr_err_i   (cmd.clr_err),
    .cnt_o       (cnt),
    .borrow_o    (borrow),
    .carry_o     (carry),
    .noise_o     (noise),
    .dir_o       (dir),
    .frozen_o    (frozen)
  );

endmodule

// File: rtl/pcnt_channel_chk.sv
module pcnt_channel_chk
  import pcnt_pkg::*;
#(
  parameter int CNT_W = 24,
  localparam int BYTES = CNT_W / 8,
  localparam int PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_wr,
  input logic [7:0]       wdata,
  input logic             up,
  input logic             dn,
  input logic             ab_en,
  input logic             idx_evt,
  input logic [1:0]       mode,
  input logic             frozen,
  input logic             carry,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preset,
  input logic [CNT_W-1:0] latch,
  input logic [PTR_W-1:0] ptr
);

  logic latch_cmd, clr_bc_cmd, xfer_cmd;
  assign latch_cmd  = ctrl_wr && (wdata[7:5] == GRP_CMD) && wdata[4];
  assign clr_bc_cmd = ctrl_wr && (wdata[7:5] == GRP_CMD) &&
                      ((wdata[3:1] == OP_CLR_BC_A) || (wdata[3:1] == OP_CLR_BC_B));
  assign xfer_cmd   = ctrl_wr && (wdata == 8'h08);

  a_r2_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr < PTR_W'(BYTES));

  a_r3_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_cmd |=> (cnt == $past(preset)));

  a_r4_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_cmd |=> $stable(latch));

  a_r6_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_en && !idx_evt && !ctrl_wr) |=> $stable(cnt));

  a_r8_range_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CM_RANGE && cnt >= preset && up && !dn && !ctrl_wr && !idx_evt)
      |=> $stable(cnt));

  a_r9_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen && !ctrl_wr && !idx_evt) |=> $stable(cnt));

  a_r11_carry_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry && !clr_bc_cmd) |=> carry);

endmodule

bind pcnt_channel pcnt_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ctrl_wr (ctrl_wr),
  .wdata   (bus_wdata_i),
  .up      (cnt_up_i),
  .dn      (cnt_dn_i),
  .ab_en   (ab_en),
  .idx_evt (idx_evt),
  .mode    (mode),
  .frozen  (frozen),
  .carry   (carry),
  .cnt     (cnt),
  .preset  (preset),
  .latch   (latch),
  .ptr     (ptr)
);

// File: tb/pcnt_channel_tb.sv
module pcnt_channel_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic up = 1'b0, dn = 1'b0, nz = 1'b0, idx = 1'b0;
  logic [7:0] rdata;
  logic [1:0] mult;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pcnt_channel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_ctrl_i(sel), .bus_wr_i(wr),
    .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cnt_up_i(up), .cnt_dn_i(dn), .noise_i(nz), .index_i(idx),
    .quad_mult_o(mult)
  );

  // behavioural reference model
  int m_cnt, m_pre, m_lat, m_ptr, m_mode, m_mult;
  bit m_b, m_c, m_nz, m_dir, m_frz, m_ab, m_pn, m_ien, m_ipol, m_iact;
  localparam int MAXC = 24'hFFFFFF;

  function automatic int m_rdata();
    if (sel) return {2'b00, m_dir, m_nz, 2'b00, m_c, m_b};
    return (m_lat >> (8 * m_ptr)) & 255;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_lat = 0; m_ptr = 0; m_mode = 0; m_mult = 0;
      m_b = 0; m_c = 0; m_nz = 0; m_dir = 0; m_frz = 0;
      m_ab = 0; m_pn = 0; m_ien = 0; m_ipol = 0; m_iact = 0;
    end else begin
      int n_cnt; int n_pre; int n_lat; int n_ptr;
      bit sb, sc, clr_bc, clr_er, xfer, evt, act, n_frz;
      n_cnt = m_cnt; n_pre = m_pre; n_lat = m_lat; n_ptr = m_ptr;
      sb = 0; sc = 0; clr_bc = 0; clr_er = 0; xfer = 0; n_frz = m_frz;
      act = (idx == m_ipol);
      evt = m_ien && act && !m_iact;
      if (wr && !sel) begin
        n_pre = (m_pre & ~(255 << (8 * m_ptr))) | (int'(wdata) << (8 * m_ptr));
        n_ptr = (m_ptr + 1) % 3;
      end
      if (rd && !sel) n_ptr = (m_ptr + 1) % 3;
      if (wr && sel) begin
        case (wdata[7:5])
          3'd0: begin
            if (wdata[0]) n_ptr = 0;
            if (wdata[4]) n_lat = m_cnt;
            xfer   = (wdata[3:1] == 3'd4);
            clr_bc = (wdata[3:1] == 3'd1) || (wdata[3:1] == 3'd2);
            clr_er = (wdata[3:1] == 3'd3);
          end
          3'd1: n_frz = 0;
          default: ;
        endcase
      end
      if (xfer || (evt && !m_pn)) begin
        n_cnt = m_pre; n_frz = 0;
      end else if (evt) begin
        n_cnt = 0; n_frz = 0;
      end else if (m_ab && (up != dn) && !m_frz) begin
        if (m_mode == 0 || m_mode == 2) begin
          if (up) begin
            if (m_cnt == MAXC) begin n_cnt = 0; sc = 1; if (m_mode == 2) n_frz = 1; end
            else n_cnt = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin n_cnt = MAXC; sb = 1; if (m_mode == 2) n_frz = 1; end
            else n_cnt = m_cnt - 1;
          end
        end else if (m_mode == 1) begin
          if (up) begin if (m_cnt >= m_pre) sc = 1; else n_cnt = m_cnt + 1; end
          else    begin if (m_cnt == 0) sb = 1; else n_cnt = m_cnt - 1; end
        end else begin
          if (up) begin if (m_cnt >= m_pre) begin n_cnt = 0; sc = 1; end else n_cnt = m_cnt + 1; end
          else    begin if (m_cnt == 0) begin n_cnt = m_pre; sb = 1; end else n_cnt = m_cnt - 1; end
        end
      end
      if (m_ab && (up != dn)) m_dir = up;
      m_b  = (m_b && !clr_bc) || sb;
      m_c  = (m_c && !clr_bc) || sc;
      m_nz = (m_nz && !clr_er) || nz;
      if (wr && sel && wdata[7:5] == 3'd1) begin m_mode = wdata[2:1]; m_mult = wdata[4:3]; end
      if (wr && sel && wdata[7:5] == 3'd2) begin m_ab = wdata[0]; m_pn = wdata[1]; end
      if (wr && sel && wdata[7:5] == 3'd3) begin m_ien = wdata[0]; m_ipol = wdata[1]; end
      m_iact = act;
      m_cnt = n_cnt; m_pre = n_pre; m_lat = n_lat; m_ptr = n_ptr; m_frz = n_frz;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      tests++;
      if (rdata !== 8'(m_rdata()) || mult !== 2'(m_mult)) begin
        fails++;
        $display("FAIL %s model: rdata=%h mult=%0d expected rdata=%h mult=%0d",
                 req, rdata, mult, 8'(m_rdata()), m_mult);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sel = 0; wr = 0; rd = 0; up = 0; dn = 0; nz = 0;
  endtask

  task automatic ctl(input logic [7:0] b);
    @(negedge clk); idle(); sel = 1; wr = 1; wdata = b;
    @(negedge clk); idle();
  endtask

  task automatic dwr(input logic [7:0] b);
    @(negedge clk); idle(); sel = 0; wr = 1; wdata = b;
    @(negedge clk); idle();
  endtask

  task automatic set_preset(input logic [23:0] v);
    ctl(8'h01);
    dwr(v[7:0]); dwr(v[15:8]); dwr(v[23:16]);
  endtask

  task automatic pulse(input bit u, input bit d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idle(); up = u; dn = d;
      @(negedge clk); idle();
    end
  endtask

  task automatic rd_byte(input string tag, input logic [7:0] exp);
    @(negedge clk); idle(); sel = 0; rd = 1;
    #1 chk(tag, rdata, exp);
    @(negedge clk); idle();
  endtask

  task automatic latch_read(input string tag, input logic [23:0] exp);
    ctl(8'h11);
    rd_byte(tag, exp[7:0]); rd_byte(tag, exp[15:8]); rd_byte(tag, exp[23:16]);
  endtask

  task automatic status(input string tag, input logic [7:0] exp);
    @(negedge clk); idle(); sel = 1;
    #1 chk(tag, rdata, exp);
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    req = "R1";
    status("R1 status", 8'h00);
    chk("R1 mult", {6'b0, mult}, 8'h00);
    latch_read("R1 latch", 24'h000000);
    // R2 R3 R4 preset load, transfer, latch
    req = "R2";
    set_preset(24'hFFFFFE);
    ctl(8'h08);
    req = "R4";
    latch_read("R3 transfer R4 bytes", 24'hFFFFFE);
    // R7 wrap and R5 status
    req = "R7";
    ctl(8'h41);
    pulse(1, 0, 3);
    latch_read("R7 up wrap", 24'h000001);
    status("R5 carry dir", 8'h22);
    // R4 latch holds while counting
    req = "R4";
    pulse(1, 0, 2);
    rd_byte("R4 hold b0", 8'h01); rd_byte("R4 hold b1", 8'h00); rd_byte("R4 hold b2", 8'h00);
    latch_read("R4 relatch", 24'h000003);
    // R11 flag clears
    req = "R11";
    ctl(8'h02);
    status("R11 clr carry", 8'h20);
    @(negedge clk); nz = 1; @(negedge clk); idle();
    status("R5 noise", 8'h30);
    ctl(8'h04);
    status("R11 noise kept", 8'h30);
    ctl(8'h06);
    status("R11 noise cleared", 8'h20);
    // R7 down wrap
    req = "R7";
    set_preset(24'h000000);
    ctl(8'h08);
    pulse(0, 1, 1);
    latch_read("R7 down wrap", 24'hFFFFFF);
    status("R7 borrow", 8'h01);
    // R6 enable gating
    req = "R6";
    pulse(1, 1, 2);
    latch_read("R6 both ignored", 24'hFFFFFF);
    ctl(8'h40);
    pulse(1, 0, 2);
    latch_read("R6 disabled", 24'hFFFFFF);
    status("R6 dir unchanged", 8'h01);
    ctl(8'h41);
    ctl(8'h04);
    // R8 range limit
    req = "R8";
    ctl(8'h22);
    set_preset(24'h000005);
    ctl(8'h08);
    pulse(1, 0, 1);
    latch_read("R8 ceiling", 24'h000005);
    status("R8 carry", 8'h22);
    ctl(8'h02);
    pulse(0, 1, 6);
    latch_read("R8 floor", 24'h000000);
    status("R8 borrow", 8'h01);
    ctl(8'h02);
    // R9 non-recycle
    req = "R9";
    ctl(8'h24);
    set_preset(24'hFFFFFF);
    ctl(8'h08);
    pulse(1, 0, 3);
    latch_read("R9 frozen", 24'h000000);
    status("R9 carry", 8'h22);
    ctl(8'h08);
    pulse(0, 1, 1);
    latch_read("R9 reload", 24'hFFFFFE);
    ctl(8'h02);
    // R10 modulo-N
    req = "R10";
    ctl(8'h26);
    set_preset(24'h000002);
    ctl(8'h08);
    pulse(1, 0, 2);
    latch_read("R10 up wrap", 24'h000001);
    pulse(0, 1, 2);
    latch_read("R10 down wrap", 24'h000002);
    status("R10 flags", 8'h03);
    ctl(8'h02);
    // R12 mode register fields
    req = "R12";
    ctl(8'h38);
    chk("R12 mult", {6'b0, mult}, 8'h03);
    // R13 index
    req = "R13";
    set_preset(24'h123456);
    ctl(8'h63);
    @(negedge clk); idx = 1; @(negedge clk); idx = 0;
    latch_read("R13 index preset", 24'h123456);
    ctl(8'h43);
    @(negedge clk); idx = 1; @(negedge clk); idx = 0;
    latch_read("R13 index clear", 24'h000000);
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule